// File: doc/BRIEF.md
# Fault Response Policy Unit

This unit decides how the system reacts when the processor reports a fault. Five fault classes arrive as single-cycle strobes: address error, bus error termination, return-from-exception format error, fault-on-fault, and an instruction-related fault such as an illegal opcode. For each fault the unit either asks for a full system reset or downgrades the event to a processor exception. Two policy bits in a small configuration register choose the outcome. One bit covers the four address-related classes. The other covers the instruction class.

In downgraded mode, a fault-on-fault cannot be turned into an exception, so the unit halts the processor instead. A reset request is a pulse of fixed length. A sticky cause register records which class triggered the most recent fault reset. This register is cleared only by power-on reset, so software can read it after the system restarts. The unit has two reset inputs. The power-on reset clears everything. The system reset, which the reset request normally drives, clears the policy bits and the halt but leaves the cause register and the pulse timer alone.

Top module: `fault_policy_unit`

## Requirements
- R1: When `cfgWd[0]` (address-class reset disable) is stored as 0, an address error, bus error, RTE format error or fault-on-fault strobe makes `rstReq` rise in the cycle after the strobe. No `excReq` and no halt result.
- R2: When the address-class disable bit is 1, an address, bus or RTE format error raises `excReq` for exactly one cycle, starting the cycle after the strobe, and no reset results. `excCode` carries the class code: 2 for bus, 3 for address, 4 for RTE format.
- R3: When the address-class disable bit is 1, a fault-on-fault sets `haltReq` in the cycle after the strobe. It raises neither `excReq` nor `rstReq`.
- R4: The instruction fault follows `cfgWd[1]` (instruction-class reset disable) only. When that bit is 0 it requests a reset. When it is 1 it raises an exception with code 5.
- R5: If several strobes occur in the same cycle, only one class is acted on. Fault-on-fault wins over bus error, bus error over address error, address error over RTE format error, and RTE format error over the instruction fault. The policy bit of the winning class decides the outcome.
- R6: A reset request holds `rstReq` high for exactly `RST_CYCLES` consecutive cycles. Strobes that arrive while it is high neither extend the pulse nor change the outcome.
- R7: `cause` loads the winning class code when, and only when, a reset is requested. The codes are 1 fault-on-fault, 2 bus, 3 address, 4 RTE format and 5 instruction. The value survives `sysRstN` and is cleared to 0 only by `porRstN`.
- R8: `haltReq` stays high until `sysRstN` or `porRstN` is asserted. Strobes that arrive while halted produce no exception, no reset and no change to `cause`.
- R9: A one-cycle `cfgWe` stores `cfgWd`. Both policy bits return to 0 on either reset, so faults request resets by default.
- R10: After power-on reset, `rstReq`, `excReq`, `haltReq` and `cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, clears all state |
| sysRstN | input | 1 | System reset, active low, clears policy bits, halt and exception outputs |
| cfgWe | input | 1 | Policy register write strobe |
| cfgWd | input | 2 | Policy bits: [0] address-class reset disable, [1] instruction-class reset disable |
| addrErr | input | 1 | Address error strobe |
| busErr | input | 1 | Bus error termination strobe |
| rteFmtErr | input | 1 | Return-from-exception format error strobe |
| faultOnFault | input | 1 | Fault-on-fault strobe |
| instrFault | input | 1 | Instruction-related fault strobe |
| rstReq | output | 1 | System reset request pulse |
| excReq | output | 1 | Processor exception request, one cycle |
| excCode | output | 3 | Class code of the requested exception |
| haltReq | output | 1 | Processor halt request |
| cause | output | 3 | Sticky code of the class behind the last fault reset |

## Verification
The bench builds the unit with `RST_CYCLES` set to 5. This keeps each reset pulse short, so every pulse can be counted edge by edge, and a second strobe can be landed inside a pulse to show that it is ignored. With the short pulse, a table covering every class under each policy setting, plus the mixed-strobe priority cases, fits into a brief run. The default value of 16 changes only the length of the counter.

// File: rtl/fault_policy_pkg.sv
package fault_policy_pkg;

  localparam int NUM_CLASSES = 5;
  localparam int CODE_W      = 3;

  typedef logic [CODE_W-1:0] faultCode_t;

  // Class codes; index in priority vector = code - 1 (lower index wins)
  localparam faultCode_t CODE_NONE  = 3'd0;
  localparam faultCode_t CODE_FOF   = 3'd1;
  localparam faultCode_t CODE_BUS   = 3'd2;
  localparam faultCode_t CODE_ADDR  = 3'd3;
  localparam faultCode_t CODE_RTE   = 3'd4;
  localparam faultCode_t CODE_INSTR = 3'd5;

  typedef struct packed {
    logic       fireRst;
    logic       fireExc;
    logic       fireHalt;
    faultCode_t code;
  } actStrobes_t;

  function automatic faultCode_t codeOfIndex(input int unsigned idx);
    return faultCode_t'(idx + 1);
  endfunction

endpackage

// File: rtl/fault_prio_pick.sv
module fault_prio_pick #(
  parameter int N = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         grant,
  output logic [$clog2(N)-1:0] grantIdx,
  output logic                 anyReq
);

  localparam int IW = $clog2(N);

  // Lower index has higher priority
  logic [N-1:0] blocked;

  assign blocked[0] = 1'b0;
  generate
    for (genvar g = 1; g < N; g++) begin : g_block
      assign blocked[g] = blocked[g-1] | req[g-1];
    end
  endgenerate

  assign grant  = req & ~blocked;
  assign anyReq = |req;

  always_comb begin
    grantIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grantIdx = IW'(i);
    end
  end

  // R5: at most one class granted, and a request always yields a grant
  p_single_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant) && (anyReq == (grant != '0)));

endmodule

// File: rtl/fault_policy_ctrl.sv
module fault_policy_ctrl
  import fault_policy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrRstDis,
  input  logic        instrRstDis,
  input  logic [NUM_CLASSES-1:0] faultVec,
  input  logic        rstActive,
  input  logic        halted,
  output actStrobes_t act
);

  localparam int IW = $clog2(NUM_CLASSES);

  logic [NUM_CLASSES-1:0] grant;
  logic [IW-1:0]          grantIdx;
  logic                   anyFault;
  faultCode_t             winCode;
  logic                   winDisable;
  logic                   accept;

  fault_prio_pick #(.N(NUM_CLASSES)) u_pick (
    .clk      (clk),
    .rstN     (rstN),
    .req      (faultVec),
    .grant    (grant),
    .grantIdx (grantIdx),
    .anyReq   (anyFault)
  );

  assign winCode    = codeOfIndex(int'(grantIdx));
  assign winDisable = (winCode == CODE_INSTR) ? instrRstDis : addrRstDis;
  // Faults are dropped while a reset pulse runs or the processor is halted
  assign accept     = anyFault && !rstActive && !halted;

  always_comb begin
    act          = '0;
    act.code     = winCode;
    if (accept) begin
      if (!winDisable)               act.fireRst  = 1'b1;
      else if (winCode == CODE_FOF)  act.fireHalt = 1'b1;
      else                           act.fireExc  = 1'b1;
    end
  end

  // R1/R2/R3: exactly one response per accepted fault
  p_one_action_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({act.fireRst, act.fireExc, act.fireHalt}));

  // R3: a fault-on-fault never becomes an exception
  p_fof_no_exc_r3: assert property (@(posedge clk) disable iff (!rstN)
    faultVec[0] |-> !act.fireExc);

endmodule

// File: rtl/fault_policy_dp.sv
module fault_policy_dp
  import fault_policy_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        sysRstN,
  input  logic        cfgWe,
  input  logic [1:0]  cfgWd,
  input  actStrobes_t act,
  output logic        addrRstDis,
  output logic        instrRstDis,
  output logic        rstActive,
  output logic        halted,
  output logic        excReq,
  output faultCode_t  excCode,
  output faultCode_t  cause
);

  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] PULSE_LOAD = CW'(RST_CYCLES);

  logic          anyRstN;
  logic [CW-1:0] pulseCnt;

  assign anyRstN = porRstN & sysRstN;

  // Policy register: cleared by either reset
  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      addrRstDis  <= 1'b0;
      instrRstDis <= 1'b0;
    end else if (cfgWe) begin
      addrRstDis  <= cfgWd[0];
      instrRstDis <= cfgWd[1];
    end
  end

  // Pulse timer and sticky cause: power-on reset only
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      pulseCnt <= '0;
      cause    <= CODE_NONE;
    end else if (act.fireRst) begin
      pulseCnt <= PULSE_LOAD;
      cause    <= act.code;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign rstActive = (pulseCnt != '0);

  // Exception and halt outputs: cleared by either reset
  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      excReq  <= 1'b0;
      excCode <= CODE_NONE;
      halted  <= 1'b0;
    end else begin
      excReq <= act.fireExc;
      if (act.fireExc)  excCode <= act.code;
      if (act.fireHalt) halted  <= 1'b1;
    end
  end

  // R8: halt holds until a reset
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!anyRstN)
    halted |=> halted);

  // R7: cause changes only together with the start of a reset pulse
  p_cause_on_rst_r7: assert property (@(posedge clk) disable iff (!porRstN)
    (cause != $past(cause)) |-> (pulseCnt == PULSE_LOAD));

  // R2/R6: exception and reset request never coexist
  p_exc_vs_rst_r2: assert property (@(posedge clk) disable iff (!anyRstN)
    !(excReq && rstActive));

  // R2: exception code always names a class that can be downgraded
  p_exc_code_r2: assert property (@(posedge clk) disable iff (!anyRstN)
    excReq |-> (excCode != CODE_NONE && excCode != CODE_FOF));

  // R3: halted processor gets no exception
  p_halt_no_exc_r3: assert property (@(posedge clk) disable iff (!anyRstN)
    halted |-> !excReq);

endmodule

// File: rtl/fault_policy_unit.sv
module fault_policy_unit
  import fault_policy_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       sysRstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgWd,
  input  logic       addrErr,
  input  logic       busErr,
  input  logic       rteFmtErr,
  input  logic       faultOnFault,
  input  logic       instrFault,
  output logic       rstReq,
  output logic       excReq,
  output logic [2:0] excCode,
  output logic       haltReq,
  output logic [2:0] cause
);

  logic [NUM_CLASSES-1:0] faultVec;
  actStrobes_t act;
  logic addrRstDis, instrRstDis, rstActive, halted;

  // Priority order: index 0 highest
  assign faultVec = {instrFault, rteFmtErr, addrErr, busErr, faultOnFault};

  fault_policy_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (porRstN),
    .addrRstDis  (addrRstDis),
    .instrRstDis (instrRstDis),
    .faultVec    (faultVec),
    .rstActive   (rstActive),
    .halted      (halted),
    .act         (act)
  );

  fault_policy_dp #(.RST_CYCLES(RST_CYCLES)) u_dp (
    .clk         (clk),
    .porRstN     (porRstN),
    .sysRstN     (sysRstN),
    .cfgWe       (cfgWe),
    .cfgWd       (cfgWd),
    .act         (act),
    .addrRstDis  (addrRstDis),
    .instrRstDis (instrRstDis),
    .rstActive   (rstActive),
    .halted      (halted),
    .excReq      (excReq),
    .excCode     (excCode),
    .cause       (cause)
  );

  assign rstReq  = rstActive;
  assign haltReq = halted;

endmodule

// File: tb/fault_policy_unit_tb.sv
module fault_policy_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 5;

  logic clk = 1'b0;
  logic porRstN = 1'b0, sysRstN = 1'b1, cfgWe = 1'b0;
  logic [1:0] cfgWd = 2'b00;
  logic addrErr = 0, busErr = 0, rteFmtErr = 0, faultOnFault = 0, instrFault = 0;
  logic rstReq, excReq, haltReq;
  logic [2:0] excCode, cause;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_policy_unit #(.RST_CYCLES(RST_CYC)) u_dut (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .cfgWe(cfgWe), .cfgWd(cfgWd),
    .addrErr(addrErr), .busErr(busErr), .rteFmtErr(rteFmtErr),
    .faultOnFault(faultOnFault), .instrFault(instrFault),
    .rstReq(rstReq), .excReq(excReq), .excCode(excCode),
    .haltReq(haltReq), .cause(cause)
  );

  // fault bits: {instr, rte, addr, bus, fof}
  typedef struct packed {
    logic [1:0] cfg;
    logic [4:0] flt;
    logic       rst;
    logic       exc;
    logic       halt;
    logic [2:0] code;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 5'b00100, 1, 0, 0, 3'd3},  // R1 address
    '{2'b00, 5'b00010, 1, 0, 0, 3'd2},  // R1 bus
    '{2'b00, 5'b01000, 1, 0, 0, 3'd4},  // R1 rte
    '{2'b00, 5'b00001, 1, 0, 0, 3'd1},  // R1 fof
    '{2'b00, 5'b10000, 1, 0, 0, 3'd5},  // R4 instr reset
    '{2'b01, 5'b00100, 0, 1, 0, 3'd3},  // R2 address exc
    '{2'b01, 5'b00010, 0, 1, 0, 3'd2},  // R2 bus exc
    '{2'b01, 5'b01000, 0, 1, 0, 3'd4},  // R2 rte exc
    '{2'b01, 5'b00001, 0, 0, 1, 3'd1},  // R3 fof halt
    '{2'b01, 5'b10000, 1, 0, 0, 3'd5},  // R4 instr independent
    '{2'b10, 5'b10000, 0, 1, 0, 3'd5},  // R4 instr exc
    '{2'b10, 5'b00100, 1, 0, 0, 3'd3},  // R4 addr unaffected
    '{2'b00, 5'b11111, 1, 0, 0, 3'd1},  // R5 all -> fof
    '{2'b01, 5'b01110, 0, 1, 0, 3'd2},  // R5 bus over addr,rte
    '{2'b01, 5'b01100, 0, 1, 0, 3'd3},  // R5 addr over rte
    '{2'b11, 5'b11000, 0, 1, 0, 3'd4},  // R5 rte over instr
    '{2'b10, 5'b10100, 1, 0, 0, 3'd3}   // R5 addr wins, its bit says reset
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_faults(input logic [4:0] f);
    {instrFault, rteFmtErr, addrErr, busErr, faultOnFault} = f;
  endtask

  task automatic sys_reset();
    @(negedge clk) sysRstN = 1'b0;
    @(negedge clk) sysRstN = 1'b1;
  endtask

  task automatic write_cfg(input logic [1:0] v);
    @(negedge clk) begin cfgWe = 1'b1; cfgWd = v; end
    @(negedge clk) cfgWe = 1'b0;
  endtask

  // pulse one strobe cycle, return at the negedge after the sampling edge
  task automatic inject(input logic [4:0] f);
    @(negedge clk) set_faults(f);
    @(negedge clk) set_faults(5'b0);
  endtask

  // count remaining cycles with rstReq high, starting at current negedge
  task automatic pulse_len(output int n);
    n = 0;
    while (rstReq && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rstReq", rstReq, 0);
    chk("R10 excReq", excReq, 0);
    chk("R10 haltReq", haltReq, 0);
    chk("R10 cause", cause, 0);

    // table
    for (int i = 0; i < NV; i++) begin
      sys_reset();
      write_cfg(VECS[i].cfg);
      inject(VECS[i].flt);
      chk($sformatf("R1/R2/R3/R4/R5 v%0d rstReq", i), rstReq, VECS[i].rst);
      chk($sformatf("R2 v%0d excReq", i), excReq, VECS[i].exc);
      chk($sformatf("R3 v%0d haltReq", i), haltReq, VECS[i].halt);
      if (VECS[i].exc) begin
        chk($sformatf("R2 v%0d excCode", i), excCode, VECS[i].code);
        @(negedge clk);
        chk($sformatf("R2 v%0d exc one cycle", i), excReq, 0);
      end
      if (VECS[i].rst) begin
        chk($sformatf("R7 v%0d cause", i), cause, VECS[i].code);
        pulse_len(n);
      end
    end

    // R6 pulse length, strobes during pulse ignored
    sys_reset();
    inject(5'b00100);
    chk("R7 cause addr", cause, 3);
    @(negedge clk) set_faults(5'b00010);
    @(negedge clk) set_faults(5'b0);
    pulse_len(n);
    chk("R6 pulse length with mid strobe", n + 2, RST_CYC);
    chk("R6 cause unchanged by ignored strobe", cause, 3);
    inject(5'b01000);
    pulse_len(n);
    chk("R6 pulse length", n, RST_CYC);
    chk("R7 cause rte", cause, 4);

    // R7 survives sysRstN, cleared by porRstN
    sys_reset();
    @(negedge clk);
    chk("R7 cause survives sysRstN", cause, 4);
    @(negedge clk) porRstN = 1'b0;
    @(negedge clk) porRstN = 1'b1;
    chk("R7 cause cleared by POR", cause, 0);

    // R8 halt holds, strobes ignored while halted
    write_cfg(2'b01);
    inject(5'b00001);
    chk("R8 halted", haltReq, 1);
    inject(5'b00100);
    chk("R8 no exc while halted", excReq, 0);
    chk("R8 no rst while halted", rstReq, 0);
    chk("R8 cause unchanged while halted", cause, 0);
    repeat (10) @(negedge clk);
    chk("R8 halt persists", haltReq, 1);
    sys_reset();
    chk("R8 halt cleared by sysRstN", haltReq, 0);

    // R9 config cleared by sysRstN
    write_cfg(2'b11);
    sys_reset();
    inject(5'b00100);
    chk("R9 addr policy default reset", rstReq, 1);
    pulse_len(n);
    sys_reset();
    write_cfg(2'b11);
    sys_reset();
    inject(5'b10000);
    chk("R9 instr policy default reset", rstReq, 1);
    chk("R9 cause instr", cause, 5);
    pulse_len(n);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule